// File: doc/BRIEF.md
# LPC Host Cycle Generator

This block is the host-side master of a four-bit multiplexed low-pin-count bus. A client presents one single-byte request on a simple request port: address, write byte, direction, cycle kind, and, for DMA, a channel and a terminal-count flag. The block then drives the framed nibble sequence for that request on a shared four-bit bus, using an output enable and a frame strobe.

At each change of bus driver it inserts a two-clock turnaround. It then waits through any number of peripheral wait codes, samples read data when the cycle has any, and returns a one-clock acknowledge or error pulse together with the read byte. If the peripheral keeps answering with wait codes for too long, the block aborts the cycle on the bus and reports an error.

The client only sees `req_ready`. A request is taken on a clock where both `req_valid` and `req_ready` are high, and `req_ready` stays low until the response pulse.

Top module: `lpc_host_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, frame strobe 0, output enable 0, bus output 1111, and no response pulse.
- R2: A cycle of kind I/O (`req_kind`=0), memory (1) or DMA (2) begins with one clock of nibble 0000 with the frame strobe high. The frame strobe is low in every other clock except during an abort.
- R3: For I/O, memory and DMA cycles, the second nibble is the cycle type. Bit 3 is 1 for DMA. Bit 2 is 1 for memory. Bit 1 is the direction bit. Bit 0 is 0.
- R4: I/O cycles send the low 16 address bits as 4 nibbles. Memory and firmware cycles send all 32 address bits as 8 nibbles. The most significant nibble goes first.
- R5: DMA cycles send no address. After the cycle type comes the nibble {tc, channel[2:0]}, then the size nibble 0000. In the cycle type, bit 1 is the inverse of `req_write`, where `req_write`=1 means the data byte travels from host to peripheral.
- R6: Firmware cycles (`req_kind`=3) begin with 1110 for a write or 1101 for a read, with the frame strobe high. They have no cycle-type nibble, and they send the size nibble 0000 after the eight address nibbles.
- R7: When data travels from host to peripheral, the write byte follows as two nibbles, low nibble first. After the last host nibble, the host drives 1111 for one clock with the enable high, then releases the bus for one clock.
- R8: The output enable is low in idle and in every clock the peripheral owns: SYNC, read data and the peripheral turnaround.
- R9: In SYNC, 0000 means ready. Any code other than 0000 or 1010 (for example 0101 or 0110) adds a wait clock. A read cycle then captures two data nibbles, low nibble first. A one-clock `rsp_ack` follows the second clock of the peripheral turnaround, with the byte on `rsp_rdata`.
- R10: The SYNC code 1010 completes the cycle like 0000, including the read data, but the block pulses `rsp_err` in place of `rsp_ack`.
- R11: After `WAIT_LIMIT` consecutive wait clocks, the block holds the frame strobe high with the enable high and 1111 on the bus for `ABORT_CLKS` clocks. It then returns to idle with a one-clock `rsp_err` pulse.
- R12: A request is taken only while `req_ready` is high. `req_valid` and request fields that change during a cycle do not alter the bus sequence and start no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | 0 I/O, 1 memory, 2 DMA, 3 firmware |
| req_write | input | 1 | 1: byte travels host to peripheral |
| req_addr | input | 4*MEM_NIBS | Cycle address |
| req_wdata | input | 8 | Byte sent to the peripheral |
| req_dma_chan | input | 3 | DMA channel number |
| req_dma_tc | input | 1 | DMA terminal count |
| rsp_ack | output | 1 | One-clock good completion |
| rsp_err | output | 1 | One-clock error completion or abort |
| rsp_rdata | output | 8 | Byte read from the peripheral |
| lpc_frame_o | output | 1 | Frame strobe, active high |
| lpc_ad_o | output | 4 | Bus nibble driven by the host |
| lpc_ad_oe | output | 1 | Host drives the bus |
| lpc_ad_i | input | 4 | Bus nibble seen from the peripheral |

## Verification
The bench builds the block with `WAIT_LIMIT`=5 and the other parameters at their defaults. The short limit puts both sides of the timeout within a few clocks: four waits still complete, and five waits abort. It sweeps all four cycle kinds in both directions over several addresses, channels and wait lengths. The wait lengths mix short, long and unknown wait codes. Some cycles end with the error SYNC, and some hold `req_valid` high with scrambled fields while the block is busy. For every cycle the bench computes the whole expected nibble stream arithmetically and compares it clock by clock.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

   typedef enum logic [1:0] {
      KIND_IO  = 2'd0,
      KIND_MEM = 2'd1,
      KIND_DMA = 2'd2,
      KIND_FW  = 2'd3
   } kind_e;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_START,
      PH_CTYPE,
      PH_ADDR,
      PH_CHAN,
      PH_SIZE,
      PH_HDATA,
      PH_HTAR,
      PH_SYNC,
      PH_PDATA,
      PH_PTAR,
      PH_ABORT
   } phase_e;

   localparam logic [3:0] NIB_START  = 4'h0;
   localparam logic [3:0] NIB_FW_RD  = 4'hD;
   localparam logic [3:0] NIB_FW_WR  = 4'hE;
   localparam logic [3:0] NIB_ONES   = 4'hF;
   localparam logic [3:0] NIB_SIZE1  = 4'h0;
   localparam logic [3:0] SYNC_READY = 4'h0;
   localparam logic [3:0] SYNC_FAULT = 4'hA;

endpackage

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch #(
   parameter int WAIT_LIMIT = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [3:0] ad_in,
   output logic       sync_ready,
   output logic       sync_fault,
   output logic       sync_timeout
);
   import lpc_host_pkg::*;

   localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_LIMIT - 1);

   logic [CNT_W-1:0] wait_cnt;

   // Ready and fault both finish the SYNC phase; every other code is a wait.
   assign sync_fault   = active && (ad_in == SYNC_FAULT);
   assign sync_ready   = active && ((ad_in == SYNC_READY) || (ad_in == SYNC_FAULT));
   assign sync_timeout = active && !sync_ready && (wait_cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_cnt <= '0;
      else if (!active)
         wait_cnt <= '0;
      else if (!sync_ready && !sync_timeout)
         wait_cnt <= wait_cnt + 1'b1;
   end

endmodule

// File: rtl/lpc_phase_ctl.sv
module lpc_phase_ctl
   import lpc_host_pkg::*;
#(
   parameter int IO_NIBS    = 4,
   parameter int MEM_NIBS   = 8,
   parameter int ABORT_CLKS = 4,
   parameter int IDX_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  kind_e            kind,
   input  logic             wr,
   input  logic             sync_ready,
   input  logic             sync_timeout,
   output phase_e           phase,
   output logic [IDX_W-1:0] idx,
   output logic             cyc_done,
   output logic             abort_done
);

   localparam logic [IDX_W-1:0] IO_LAST   = IDX_W'(IO_NIBS - 1);
   localparam logic [IDX_W-1:0] MEM_LAST  = IDX_W'(MEM_NIBS - 1);
   localparam logic [IDX_W-1:0] AB_LAST   = IDX_W'(ABORT_CLKS - 1);
   localparam logic [IDX_W-1:0] PAIR_LAST = IDX_W'(1);

   phase_e           nxt;
   logic [IDX_W-1:0] addr_last;

   assign addr_last = (kind == KIND_IO) ? IO_LAST : MEM_LAST;

   always_comb begin
      nxt = phase;
      case (phase)
         PH_IDLE:  if (start) nxt = PH_START;
         PH_START: nxt = (kind == KIND_FW) ? PH_ADDR : PH_CTYPE;
         PH_CTYPE: nxt = (kind == KIND_DMA) ? PH_CHAN : PH_ADDR;
         PH_ADDR:
            if (idx == addr_last)
               nxt = (kind == KIND_FW) ? PH_SIZE : (wr ? PH_HDATA : PH_HTAR);
         PH_CHAN:  nxt = PH_SIZE;
         PH_SIZE:  nxt = wr ? PH_HDATA : PH_HTAR;
         PH_HDATA: if (idx == PAIR_LAST) nxt = PH_HTAR;
         PH_HTAR:  if (idx == PAIR_LAST) nxt = PH_SYNC;
         PH_SYNC:
            if (sync_ready)        nxt = wr ? PH_PTAR : PH_PDATA;
            else if (sync_timeout) nxt = PH_ABORT;
         PH_PDATA: if (idx == PAIR_LAST) nxt = PH_PTAR;
         PH_PTAR:  if (idx == PAIR_LAST) nxt = PH_IDLE;
         PH_ABORT: if (idx == AB_LAST)   nxt = PH_IDLE;
         default:  nxt = PH_IDLE;
      endcase
   end

   assign cyc_done   = (phase == PH_PTAR)  && (idx == PAIR_LAST);
   assign abort_done = (phase == PH_ABORT) && (idx == AB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
      end else begin
         phase <= nxt;
         idx   <= (nxt != phase) ? '0 : idx + 1'b1;
      end
   end

endmodule

// File: rtl/lpc_nibble_sel.sv
module lpc_nibble_sel
   import lpc_host_pkg::*;
#(
   parameter int IO_NIBS  = 4,
   parameter int MEM_NIBS = 8,
   parameter int IDX_W    = 3
) (
   input  phase_e              phase,
   input  logic [IDX_W-1:0]    idx,
   input  kind_e               kind,
   input  logic                wr,
   input  logic [MEM_NIBS*4-1:0] addr,
   input  logic [7:0]          wdata,
   input  logic [2:0]          chan,
   input  logic                tc,
   output logic [3:0]          ad,
   output logic                oe,
   output logic                frame
);

   localparam int AW    = MEM_NIBS * 4;
   localparam int SHIFT = 4 * (MEM_NIBS - IO_NIBS);

   logic [AW-1:0] aligned;
   logic [AW-1:0] shifted;
   logic [3:0]    addr_nib;
   logic [3:0]    ctype;

   // A short I/O address is moved to the top so one shifter serves both lengths.
   generate
      if (SHIFT == 0) begin : g_same_len
         assign aligned = addr;
      end else begin : g_align
         assign aligned = (kind == KIND_IO) ? (addr << SHIFT) : addr;
      end
   endgenerate

   assign shifted  = aligned << {idx, 2'b00};
   assign addr_nib = shifted[AW-1 -: 4];
   assign ctype    = {kind == KIND_DMA, kind == KIND_MEM,
                      (kind == KIND_DMA) ? ~wr : wr, 1'b0};

   always_comb begin
      ad    = NIB_ONES;
      oe    = 1'b1;
      frame = 1'b0;
      case (phase)
         PH_START: begin
            frame = 1'b1;
            if (kind == KIND_FW) ad = wr ? NIB_FW_WR : NIB_FW_RD;
            else                 ad = NIB_START;
         end
         PH_CTYPE: ad = ctype;
         PH_ADDR:  ad = addr_nib;
         PH_CHAN:  ad = {tc, chan};
         PH_SIZE:  ad = NIB_SIZE1;
         PH_HDATA: ad = idx[0] ? wdata[7:4] : wdata[3:0];
         PH_HTAR:  oe = !idx[0];
         PH_ABORT: frame = 1'b1;
         default:  oe = 1'b0;
      endcase
   end

endmodule

// File: rtl/lpc_host_seq.sv
module lpc_host_seq
   import lpc_host_pkg::*;
#(
   parameter int WAIT_LIMIT = 32,
   parameter int ABORT_CLKS = 4,
   parameter int IO_NIBS    = 4,
   parameter int MEM_NIBS   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [1:0]            req_kind,
   input  logic                  req_write,
   input  logic [MEM_NIBS*4-1:0] req_addr,
   input  logic [7:0]            req_wdata,
   input  logic [2:0]            req_dma_chan,
   input  logic                  req_dma_tc,
   output logic                  rsp_ack,
   output logic                  rsp_err,
   output logic [7:0]            rsp_rdata,
   output logic                  lpc_frame_o,
   output logic [3:0]            lpc_ad_o,
   output logic                  lpc_ad_oe,
   input  logic [3:0]            lpc_ad_i
);

   localparam int AW    = MEM_NIBS * 4;
   localparam int MAXC  = (MEM_NIBS > ABORT_CLKS) ?
                          ((MEM_NIBS > 2) ? MEM_NIBS : 2) :
                          ((ABORT_CLKS > 2) ? ABORT_CLKS : 2);
   localparam int IDX_W = $clog2(MAXC);

   generate
      if (IO_NIBS < 1 || IO_NIBS > MEM_NIBS) begin : g_bad_nibs
         initial $fatal(1, "lpc_host_seq: IO_NIBS must lie in 1..MEM_NIBS");
      end
      if (WAIT_LIMIT < 1) begin : g_bad_wait
         initial $fatal(1, "lpc_host_seq: WAIT_LIMIT must be at least 1");
      end
      if (ABORT_CLKS < 1) begin : g_bad_abort
         initial $fatal(1, "lpc_host_seq: ABORT_CLKS must be at least 1");
      end
   endgenerate

   phase_e           phase;
   logic [IDX_W-1:0] idx;
   logic             accept;
   logic             cyc_done, abort_done;
   logic             sync_ready, sync_fault, sync_timeout;

   kind_e            kind_q;
   logic             wr_q;
   logic [AW-1:0]    addr_q;
   logic [7:0]       wdata_q;
   logic [2:0]       chan_q;
   logic             tc_q;
   logic             fault_q;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= KIND_IO;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         chan_q  <= '0;
         tc_q    <= 1'b0;
      end else if (accept) begin
         kind_q  <= kind_e'(req_kind);
         wr_q    <= req_write;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         chan_q  <= req_dma_chan;
         tc_q    <= req_dma_tc;
      end
   end

   lpc_phase_ctl #(
      .IO_NIBS(IO_NIBS), .MEM_NIBS(MEM_NIBS),
      .ABORT_CLKS(ABORT_CLKS), .IDX_W(IDX_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .kind(kind_q), .wr(wr_q),
      .sync_ready(sync_ready), .sync_timeout(sync_timeout),
      .phase(phase), .idx(idx),
      .cyc_done(cyc_done), .abort_done(abort_done)
   );

   lpc_sync_watch #(.WAIT_LIMIT(WAIT_LIMIT)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .active(phase == PH_SYNC), .ad_in(lpc_ad_i),
      .sync_ready(sync_ready), .sync_fault(sync_fault),
      .sync_timeout(sync_timeout)
   );

   lpc_nibble_sel #(
      .IO_NIBS(IO_NIBS), .MEM_NIBS(MEM_NIBS), .IDX_W(IDX_W)
   ) u_nib (
      .phase(phase), .idx(idx), .kind(kind_q), .wr(wr_q),
      .addr(addr_q), .wdata(wdata_q), .chan(chan_q), .tc(tc_q),
      .ad(lpc_ad_o), .oe(lpc_ad_oe), .frame(lpc_frame_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q   <= 1'b0;
         rsp_rdata <= '0;
         rsp_ack   <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         if (accept)
            fault_q <= 1'b0;
         else if (sync_ready)
            fault_q <= sync_fault;
         if (phase == PH_PDATA) begin
            if (idx[0]) rsp_rdata[7:4] <= lpc_ad_i;
            else        rsp_rdata[3:0] <= lpc_ad_i;
         end
         rsp_ack <= cyc_done && !fault_q;
         rsp_err <= (cyc_done && fault_q) || abort_done;
      end
   end

endmodule

// File: rtl/lpc_host_chk.sv
module lpc_host_chk
   import lpc_host_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             lpc_frame_o,
   input logic             lpc_ad_oe,
   input logic [3:0]       lpc_ad_o,
   input logic             rsp_ack,
   input logic             rsp_err,
   input phase_e           phase,
   input logic [IDX_W-1:0] idx
);

   // R8
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !lpc_ad_oe);

   // R8
   oe_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SYNC || phase == PH_PDATA || phase == PH_PTAR) |-> !lpc_ad_oe);

   // R11
   abort_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ABORT) |-> (lpc_frame_o && lpc_ad_oe && lpc_ad_o == 4'hF));

   // R10
   rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_ack && rsp_err));

   // R12
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && lpc_frame_o));

   // R7
   htar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HTAR && idx == '0) |=> (phase == PH_HTAR && !lpc_ad_oe));

   // R2
   frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpc_frame_o |-> (phase == PH_START || phase == PH_ABORT));

   // R9
   rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> $past(!req_ready));

endmodule

bind lpc_host_seq lpc_host_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .lpc_frame_o(lpc_frame_o), .lpc_ad_oe(lpc_ad_oe), .lpc_ad_o(lpc_ad_o),
   .rsp_ack(rsp_ack), .rsp_err(rsp_err), .phase(phase), .idx(idx)
);

// File: tb/tb_lpc_host_seq.sv
`timescale 1ns/1ps
module tb_lpc_host_seq;

   localparam int LIM = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = 2'd0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [2:0]  req_dma_chan = '0;
   logic        req_dma_tc = 1'b0;
   logic        rsp_ack, rsp_err;
   logic [7:0]  rsp_rdata;
   logic        lpc_frame_o, lpc_ad_oe;
   logic [3:0]  lpc_ad_o;
   logic [3:0]  lpc_ad_i = 4'hF;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lpc_host_seq #(.WAIT_LIMIT(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_dma_chan(req_dma_chan), .req_dma_tc(req_dma_tc),
      .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .lpc_frame_o(lpc_frame_o), .lpc_ad_o(lpc_ad_o), .lpc_ad_oe(lpc_ad_oe),
      .lpc_ad_i(lpc_ad_i)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] wait_code(input int w);
      case (w % 3)
         0:       return 4'h5;
         1:       return 4'h6;
         default: return 4'h9;
      endcase
   endfunction

   task automatic run_cyc(input logic [1:0] kind, input logic wr,
                          input logic [31:0] addr, input logic [7:0] wd,
                          input logic [2:0] ch, input logic tc,
                          input int nwait, input logic [3:0] fin,
                          input logic [7:0] rd, input bit hold);
      logic [3:0] e [0:15];
      string      t [0:15];
      int         n = 0;
      bit         fault;
      // expected host-driven nibbles
      if (kind == 2'd3) begin
         e[n] = wr ? 4'hE : 4'hD; t[n] = "R6"; n++;
      end else begin
         e[n] = 4'h0; t[n] = "R2"; n++;
         e[n] = {kind == 2'd2, kind == 2'd1, (kind == 2'd2) ? ~wr : wr, 1'b0};
         t[n] = "R3"; n++;
      end
      if (kind == 2'd2) begin
         e[n] = {tc, ch}; t[n] = "R5"; n++;
         e[n] = 4'h0;     t[n] = "R5"; n++;
      end else begin
         for (int j = 0; j < ((kind == 2'd0) ? 4 : 8); j++) begin
            int na = (kind == 2'd0) ? 4 : 8;
            e[n] = addr[4*(na-1-j) +: 4]; t[n] = "R4"; n++;
         end
         if (kind == 2'd3) begin
            e[n] = 4'h0; t[n] = "R6"; n++;
         end
      end
      if (wr) begin
         e[n] = wd[3:0]; t[n] = "R7"; n++;
         e[n] = wd[7:4]; t[n] = "R7"; n++;
      end

      @(negedge clk);
      chk(req_ready, "R12 ready before request", {31'd0, req_ready}, 32'd1);
      req_kind = kind; req_write = wr; req_addr = addr; req_wdata = wd;
      req_dma_chan = ch; req_dma_tc = tc; req_valid = 1'b1;
      @(negedge clk);
      if (hold) begin
         req_kind = ~kind; req_write = ~wr; req_addr = ~addr;
         req_wdata = ~wd; req_dma_chan = ~ch; req_dma_tc = ~tc;
      end else begin
         req_valid = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         chk(lpc_frame_o == (i == 0) && lpc_ad_oe && lpc_ad_o == e[i], t[i],
             {26'd0, lpc_frame_o, lpc_ad_oe, lpc_ad_o}, {26'd0, i == 0, 1'b1, e[i]});
      end
      @(negedge clk);
      chk(!lpc_frame_o && lpc_ad_oe && lpc_ad_o == 4'hF, "R7 host tar drive",
          {27'd0, lpc_frame_o, lpc_ad_oe, lpc_ad_o}, {27'd0, 1'b0, 1'b1, 4'hF});
      @(negedge clk);
      chk(!lpc_ad_oe, "R7 host tar release", {31'd0, lpc_ad_oe}, 32'd0);
      for (int w = 0; w < nwait && w < LIM; w++) begin
         @(negedge clk);
         lpc_ad_i = wait_code(w);
         chk(!lpc_ad_oe && !lpc_frame_o, "R8 wait sync",
             {30'd0, lpc_frame_o, lpc_ad_oe}, 32'd0);
      end
      if (nwait >= LIM) begin
         for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            lpc_ad_i = 4'hF;
            if (a == 3) req_valid = 1'b0;
            chk(lpc_frame_o && lpc_ad_oe && lpc_ad_o == 4'hF, "R11 abort frame",
                {26'd0, lpc_frame_o, lpc_ad_oe, lpc_ad_o}, {26'd0, 2'b11, 4'hF});
         end
         @(negedge clk);
         chk(rsp_err && !rsp_ack && req_ready, "R11 abort response",
             {29'd0, rsp_err, rsp_ack, req_ready}, {29'd0, 3'b101});
         @(negedge clk);
         chk(!rsp_err && !lpc_frame_o, "R11 single pulse",
             {30'd0, rsp_err, lpc_frame_o}, 32'd0);
         return;
      end
      @(negedge clk);
      lpc_ad_i = fin;
      chk(!lpc_ad_oe, "R8 final sync", {31'd0, lpc_ad_oe}, 32'd0);
      if (!wr) begin
         @(negedge clk);
         lpc_ad_i = rd[3:0];
         chk(!lpc_ad_oe, "R8 read data low", {31'd0, lpc_ad_oe}, 32'd0);
         @(negedge clk);
         lpc_ad_i = rd[7:4];
         chk(!lpc_ad_oe, "R8 read data high", {31'd0, lpc_ad_oe}, 32'd0);
      end
      @(negedge clk);
      lpc_ad_i = 4'hF;
      chk(!lpc_ad_oe && !rsp_ack && !rsp_err, "R8 periph tar",
          {29'd0, lpc_ad_oe, rsp_ack, rsp_err}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!lpc_ad_oe && !req_ready, "R8 periph tar end",
          {30'd0, lpc_ad_oe, req_ready}, 32'd0);
      @(negedge clk);
      fault = (fin == 4'hA);
      if (fault)
         chk(rsp_err && !rsp_ack, "R10 error response",
             {30'd0, rsp_err, rsp_ack}, 32'd2);
      else
         chk(rsp_ack && !rsp_err, "R9 ack response",
             {30'd0, rsp_ack, rsp_err}, 32'd2);
      if (!wr)
         chk(rsp_rdata == rd, fault ? "R10 read byte" : "R9 read byte",
             {24'd0, rsp_rdata}, {24'd0, rd});
      chk(req_ready && !lpc_frame_o, "R12 back to idle",
          {30'd0, req_ready, lpc_frame_o}, 32'd2);
      @(negedge clk);
      chk(!rsp_ack && !rsp_err && !lpc_frame_o && req_ready, "R12 no stray cycle",
          {28'd0, rsp_ack, rsp_err, lpc_frame_o, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !lpc_frame_o && !lpc_ad_oe && lpc_ad_o == 4'hF &&
          !rsp_ack && !rsp_err, "R1 reset state",
          {24'd0, req_ready, lpc_frame_o, lpc_ad_oe, rsp_ack, lpc_ad_o},
          {24'd0, 1'b1, 3'b000, 4'hF});
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !lpc_frame_o && !lpc_ad_oe && lpc_ad_o == 4'hF,
          "R1 idle after reset", {26'd0, req_ready, lpc_frame_o, lpc_ad_oe, lpc_ad_o},
          {26'd0, 1'b1, 2'b00, 4'hF});

      for (int k = 0; k < 4; k++)
         for (int wr = 0; wr < 2; wr++)
            for (int a = 0; a < 3; a++) begin
               logic [31:0] ad;
               ad = (32'h1234_5678 * (a + 1)) ^ (32'h0F0F_00A5 * k);
               run_cyc(k[1:0], wr[0], ad, ad[15:8] ^ 8'hC3, 3'(a + k), a[0],
                       (k + a + wr) % 4, (a == 2) ? 4'hA : 4'h0,
                       ad[7:0] ^ 8'h5A, a == 1);
            end

      // timeout boundary: LIM-1 waits complete, LIM waits abort (R11)
      run_cyc(2'd1, 1'b0, 32'hDEAD_BEEF, 8'h00, 3'd0, 1'b0, LIM - 1, 4'h0, 8'hA7, 1'b0);
      run_cyc(2'd1, 1'b0, 32'hDEAD_BEEF, 8'h00, 3'd0, 1'b0, LIM, 4'h0, 8'hA7, 1'b0);
      run_cyc(2'd2, 1'b1, 32'h0, 8'h3C, 3'd7, 1'b1, LIM, 4'h0, 8'h00, 1'b1);
      run_cyc(2'd3, 1'b1, 32'hFFFF_FFFF, 8'hFF, 3'd0, 1'b0, LIM + 3, 4'h0, 8'h00, 1'b0);
      run_cyc(2'd0, 1'b0, 32'h0000_FFFF, 8'h00, 3'd0, 1'b0, 0, 4'h0, 8'h00, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule